// File: doc/BRIEF.md
# Convolution Window Matrix Mapper

This block turns a stream of input feature rows into the rows of the expanded convolution matrix, one block at a time, without ever holding that expanded matrix. Each input channel keeps a small rolling line store of `k + stride` feature rows. Each stored row is `COLS` pixels wide and is split across per-column banks. For every output row position the block walks the channels. For each channel it walks the `k` window rows, and for each window row it reads the stored row `k` times, shifted one column further each time. Every read yields one matrix row `COLS` pixels wide. A block is therefore `C*k*k` rows long and is emitted at one row per cycle into a downstream feature FIFO through a valid/ready handshake.

Columns and rows that fall outside the feature map because of padding come out as zero. While one block is being emitted, the rows needed by the next vertical slide are already being accepted into the free slots of the line store. A per-channel ring pointer decides which physical slot holds which feature row, so retired rows are simply overwritten and never copied. Kernel size, vertical stride, padding and feature height are sampled when a run starts.

Top module: `cwm_mapper`

## Requirements
- R1: After reset, `busy`, `outValid` and `inReady` are all low.
- R2: Within a block, rows are emitted channel by channel. Inside a channel they go window row `rr` outer and column offset `cc` inner, both counting from 0 to k-1. Lane `j` of a row carries input pixel (channel, row `top+rr`, column `j+cc-pad`), where `top = oy*stride - pad` for output row position `oy`.
- R3: Any lane whose source row is below 0 or at least the height, or whose source column is below 0 or at least `COLS`, is zero.
- R4: A run emits exactly `C*k*k*(floor((H+2*pad-k)/stride)+1)` rows, and `busy` falls in the cycle after the last row is accepted.
- R5: While `outValid` is high and `outReady` is low, `outValid` stays high and `outData` stays unchanged.
- R6: Input rows arrive in feature-row order, with channel 0 first within each row, one channel row per beat. `inReady` is high exactly while the block is busy, fewer than H rows have been fully loaded, and the row being loaded minus the current window top is less than `k+stride`. This lets the next `stride` rows load while the current block is emitted.
- R7: `outValid` is high whenever the block is busy and the source row of the current matrix row has been loaded for that channel, or lies outside the map. With ready held high and rows available, one matrix row is emitted per cycle.
- R8: `cfgK`, `cfgStride`, `cfgPad` and `cfgHeight` are sampled on `start` while idle. A `start` pulse during a run is ignored, and the run continues with its original settings.
- R9: Pixels are 16-bit signed values (1 sign, 7 integer, 8 fraction bits) and pass through unchanged, negative values included.
- R10: A line-store slot being written never holds a row that the current matrix row reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (sampled only while idle) |
| cfgK | input | K_W | Kernel size k (1..KMAX) |
| cfgStride | input | S_W | Vertical stride (1..SMAX) |
| cfgPad | input | P_W | Padding, less than k |
| cfgHeight | input | H_W | Feature height H |
| inValid | input | 1 | Input row beat valid |
| inReady | output | 1 | Input row beat accepted |
| inPix | input | COLS*16 | One channel row; lane j in bits j*16 +: 16 |
| outValid | output | 1 | Matrix row valid |
| outReady | input | 1 | Feature FIFO can take a row |
| outData | output | COLS*16 | Matrix row; lane j in bits j*16 +: 16 |
| busy | output | 1 | Run in progress |

## Verification
The bench goes after the ring wrap-around under strides of 1 and 2, and after padding on all four edges. A wrong slot pointer would return stale pixels from an earlier row, and wrong pad handling would leak real pixels into zero lanes or shift every lane by one. Random back-pressure on both sides checks that a stall freezes the output row and that prefetch never outruns the window: an overrun would corrupt a row before it is read, while an over-cautious limit would show up as a cycle where `inReady` differs from the model. A `start` pulse during a run checks that the settings stay latched. A block that accepted that pulse would emit the wrong number of rows.

// File: rtl/cwm_pkg.sv
package cwm_pkg;
  localparam int PIX_W    = 16;
  localparam int CHANNELS = 2;
  localparam int COLS     = 4;
  localparam int KMAX     = 3;
  localparam int SMAX     = 2;
  localparam int PMAX     = 1;
  localparam int HMAX     = 15;

  localparam int NSLOT  = KMAX + SMAX;
  localparam int CH_W   = (CHANNELS > 1) ? $clog2(CHANNELS) : 1;
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1;
  localparam int K_W    = $clog2(KMAX + 1);
  localparam int S_W    = $clog2(SMAX + 1);
  localparam int P_W    = (PMAX > 0) ? $clog2(PMAX + 1) : 1;
  localparam int H_W    = $clog2(HMAX + 1);
  localparam int ROW_W  = H_W + 3;

  typedef logic signed [PIX_W-1:0] pix_t;

  // strobes from control to line store / read mux
  typedef struct packed {
    logic              wrEn;
    logic [CH_W-1:0]   wrCh;
    logic [SLOT_W-1:0] wrSlot;
    logic              rdEn;
    logic              rdZero;
    logic [CH_W-1:0]   rdCh;
    logic [SLOT_W-1:0] rdSlot;
    logic [K_W-1:0]    shift;
    logic [P_W-1:0]    pad;
  } strobe_t;
endpackage

// File: rtl/cwm_linestore.sv
module cwm_linestore
  import cwm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strb,
  input  logic [COLS*PIX_W-1:0] inPix,
  output logic [COLS*PIX_W-1:0] outPix
);
  // one bank per column, each bank holds NSLOT rows for every channel
  pix_t bankMem [CHANNELS][NSLOT][COLS];

  always_ff @(posedge clk) begin
    if (strb.wrEn) begin
      for (int j = 0; j < COLS; j++) begin
        bankMem[strb.wrCh][strb.wrSlot][j] <= inPix[j*PIX_W +: PIX_W];
      end
    end
  end

  // shifted read; lanes that land in the pad region read as zero
  for (genvar j = 0; j < COLS; j++) begin : g_lane
    int srcCol;
    always_comb begin
      srcCol = j + int'(strb.shift) - int'(strb.pad);
      if (strb.rdZero || srcCol < 0 || srcCol >= COLS) begin
        outPix[j*PIX_W +: PIX_W] = '0;
      end else begin
        outPix[j*PIX_W +: PIX_W] = bankMem[strb.rdCh][strb.rdSlot][srcCol[COL_W-1:0]];
      end
    end
  end

  // R10
  slot_no_clobber_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.rdEn && !strb.rdZero && strb.wrCh == strb.rdCh)
      |-> strb.wrSlot != strb.rdSlot);
endmodule

// File: rtl/cwm_ctrl.sv
module cwm_ctrl
  import cwm_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic [K_W-1:0] cfgK,
  input  logic [S_W-1:0] cfgStride,
  input  logic [P_W-1:0] cfgPad,
  input  logic [H_W-1:0] cfgHeight,
  input  logic           inValid,
  output logic           inReady,
  input  logic           outReady,
  output logic           outValid,
  output logic           busy,
  output strobe_t        strb
);
  logic                    busyQ;
  logic [K_W-1:0]          kQ;
  logic [S_W-1:0]          sQ;
  logic [P_W-1:0]          pQ;
  logic [H_W-1:0]          hQ;
  logic signed [ROW_W-1:0] topQ;
  logic [SLOT_W-1:0]       topSlotQ, loadSlotQ;
  logic [CH_W-1:0]         chQ, loadChQ;
  logic [K_W-1:0]          rrQ, ccQ;
  logic [H_W:0]            loadRowQ;

  int   ringLen, absRow, loadRowI, slotSum, rdSlotI;
  int   nextTop, nextTopSlot, nextLoadSlot;
  logic outOfRange, rowLoaded, lastBlock;

  always_comb begin
    ringLen      = int'(kQ) + int'(sQ);
    absRow       = int'(topQ) + int'(rrQ);
    loadRowI     = int'(loadRowQ);
    outOfRange   = (absRow < 0) || (absRow >= int'(hQ));
    rowLoaded    = (absRow < loadRowI) || ((absRow == loadRowI) && (chQ < loadChQ));
    outValid     = busyQ && (outOfRange || rowLoaded);
    inReady      = busyQ && (loadRowI < int'(hQ)) && ((loadRowI - int'(topQ)) < ringLen);
    slotSum      = int'(topSlotQ) + int'(rrQ);
    rdSlotI      = (slotSum >= ringLen) ? slotSum - ringLen : slotSum;
    nextTop      = int'(topQ) + int'(sQ);
    nextTopSlot  = int'(topSlotQ) + int'(sQ);
    if (nextTopSlot >= ringLen) nextTopSlot = nextTopSlot - ringLen;
    nextLoadSlot = int'(loadSlotQ) + 1;
    if (nextLoadSlot >= ringLen) nextLoadSlot = 0;
    lastBlock    = (nextTop + int'(kQ)) > (int'(hQ) + int'(pQ));

    strb.wrEn   = inValid && inReady;
    strb.wrCh   = loadChQ;
    strb.wrSlot = loadSlotQ;
    strb.rdEn   = outValid;
    strb.rdZero = outOfRange;
    strb.rdCh   = chQ;
    strb.rdSlot = SLOT_W'(rdSlotI);
    strb.shift  = ccQ;
    strb.pad    = pQ;
  end

  assign busy = busyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;  kQ <= '0;  sQ <= '0;  pQ <= '0;  hQ <= '0;
      topQ <= '0;  topSlotQ <= '0;  loadSlotQ <= '0;
      chQ <= '0;  loadChQ <= '0;  rrQ <= '0;  ccQ <= '0;  loadRowQ <= '0;
    end else if (!busyQ) begin
      if (start) begin
        busyQ     <= 1'b1;
        kQ        <= cfgK;
        sQ        <= cfgStride;
        pQ        <= cfgPad;
        hQ        <= cfgHeight;
        topQ      <= ROW_W'(-int'(cfgPad));
        topSlotQ  <= (cfgPad == '0) ? '0
                     : SLOT_W'(int'(cfgK) + int'(cfgStride) - int'(cfgPad));
        loadSlotQ <= '0;
        chQ       <= '0;
        loadChQ   <= '0;
        rrQ       <= '0;
        ccQ       <= '0;
        loadRowQ  <= '0;
      end
    end else begin
      if (inValid && inReady) begin
        if (loadChQ == CH_W'(CHANNELS - 1)) begin
          loadChQ   <= '0;
          loadRowQ  <= loadRowQ + 1'b1;
          loadSlotQ <= SLOT_W'(nextLoadSlot);
        end else begin
          loadChQ <= loadChQ + 1'b1;
        end
      end
      if (outValid && outReady) begin
        if (ccQ != kQ - 1'b1) begin
          ccQ <= ccQ + 1'b1;
        end else begin
          ccQ <= '0;
          if (rrQ != kQ - 1'b1) begin
            rrQ <= rrQ + 1'b1;
          end else begin
            rrQ <= '0;
            if (chQ != CH_W'(CHANNELS - 1)) begin
              chQ <= chQ + 1'b1;
            end else begin
              chQ      <= '0;
              topQ     <= ROW_W'(nextTop);
              topSlotQ <= SLOT_W'(nextTopSlot);
              if (lastBlock) busyQ <= 1'b0;
            end
          end
        end
      end
    end
  end

  // R5
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);
  // R6
  no_load_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !inReady);
  // R8
  start_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
endmodule

// File: rtl/cwm_mapper.sv
module cwm_mapper
  import cwm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [K_W-1:0]        cfgK,
  input  logic [S_W-1:0]        cfgStride,
  input  logic [P_W-1:0]        cfgPad,
  input  logic [H_W-1:0]        cfgHeight,
  input  logic                  inValid,
  output logic                  inReady,
  input  logic [COLS*PIX_W-1:0] inPix,
  output logic                  outValid,
  input  logic                  outReady,
  output logic [COLS*PIX_W-1:0] outData,
  output logic                  busy
);
  strobe_t strb;

  cwm_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .cfgK      (cfgK),
    .cfgStride (cfgStride),
    .cfgPad    (cfgPad),
    .cfgHeight (cfgHeight),
    .inValid   (inValid),
    .inReady   (inReady),
    .outReady  (outReady),
    .outValid  (outValid),
    .busy      (busy),
    .strb      (strb)
  );

  cwm_linestore store_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .inPix  (inPix),
    .outPix (outData)
  );

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(outData));
endmodule

// File: tb/cwm_mapper_tb_top.sv
`timescale 1ns/1ps
module cwm_mapper_tb_top;
  import cwm_pkg::*;

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic                  start = 1'b0;
  logic [K_W-1:0]        cfgK = '0;
  logic [S_W-1:0]        cfgStride = '0;
  logic [P_W-1:0]        cfgPad = '0;
  logic [H_W-1:0]        cfgHeight = '0;
  logic                  inValid = 1'b0;
  logic                  inReady;
  logic [COLS*PIX_W-1:0] inPix = '0;
  logic                  outValid;
  logic                  outReady = 1'b0;
  logic [COLS*PIX_W-1:0] outData;
  logic                  busy;

  always #2 clk = ~clk;

  cwm_mapper dut_i (.*);

  int checks = 0, fails = 0;
  bit runOn = 0;
  int mode = 0;
  bit reqStart = 0;
  int reqK, reqS, reqP, reqH;
  // reference model state
  bit mBusy = 0;
  int mK, mS, mP, mH, mTop, mCh, mRr, mCc, mLRow, mLCh;
  int fired = 0, negSeen = 0;
  bit prevStall = 0;
  logic [COLS*PIX_W-1:0] prevData;

  function automatic pix_t pixVal(int c, int r, int col);
    int v;
    v = ((c*53 + r*29 + col*17) % 97) - 48;
    return pix_t'(v * 300);
  endfunction

  function automatic logic [COLS*PIX_W-1:0] loadRow(int c, int r);
    logic [COLS*PIX_W-1:0] v;
    for (int j = 0; j < COLS; j++) v[j*PIX_W +: PIX_W] = pixVal(c, r, j);
    return v;
  endfunction

  task automatic check(bit ok, string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  always @(negedge clk) begin
    if (runOn) begin
      bit expV, expR, padHit, newReady, newInValid, newStart, fire, acc;
      int absRow;
      logic [COLS*PIX_W-1:0] expRow;
      absRow = mTop + mRr;
      expV = mBusy && ((absRow < 0) || (absRow >= mH) || (absRow < mLRow)
                       || (absRow == mLRow && mCh < mLCh));
      expR = mBusy && (mLRow < mH) && ((mLRow - mTop) < (mK + mS));
      check(busy == mBusy, $sformatf("R4 busy act=%0d exp=%0d", busy, mBusy));
      check(outValid == expV, $sformatf("R7 outValid act=%0d exp=%0d", outValid, expV));
      check(inReady == expR, $sformatf("R6 inReady act=%0d exp=%0d", inReady, expR));
      if (expV && outValid) begin
        padHit = 0;
        for (int j = 0; j < COLS; j++) begin
          int src;
          src = j + mCc - mP;
          if (absRow < 0 || absRow >= mH || src < 0 || src >= COLS) begin
            expRow[j*PIX_W +: PIX_W] = '0;
            padHit = 1;
          end else begin
            expRow[j*PIX_W +: PIX_W] = pixVal(mCh, absRow, src);
          end
          if (outData[j*PIX_W + PIX_W - 1]) negSeen++;
        end
        check(outData == expRow, $sformatf("%s data ch=%0d row=%0d cc=%0d act=%h exp=%h",
              padHit ? "R3" : "R2", mCh, absRow, mCc, outData, expRow));
      end
      if (prevStall) begin
        check(outValid && outData == prevData,
              $sformatf("R5 stall hold act=%0d/%h exp=1/%h", outValid, outData, prevData));
      end
      // drive next inputs
      newReady   = (mode == 0) ? 1'b1 : ($urandom_range(0, 3) != 0);
      newInValid = mBusy && (mLRow < mH) && ((mode == 0) || ($urandom_range(0, 2) != 0));
      newStart   = reqStart;
      reqStart   = 0;
      if (newStart) begin
        cfgK = K_W'(reqK); cfgStride = S_W'(reqS); cfgPad = P_W'(reqP); cfgHeight = H_W'(reqH);
      end
      start    = newStart;
      outReady = newReady;
      inValid  = newInValid;
      inPix    = (mLRow < mH) ? loadRow(mLCh, mLRow) : '0;
      fire = expV && newReady;
      acc  = expR && newInValid;
      prevStall = expV && !newReady;
      prevData  = outData;
      // model step for the coming edge
      if (!mBusy) begin
        if (newStart) begin
          mBusy = 1; mK = reqK; mS = reqS; mP = reqP; mH = reqH;
          mTop = -reqP; mCh = 0; mRr = 0; mCc = 0; mLRow = 0; mLCh = 0;
        end
      end else begin
        if (acc) begin
          if (mLCh == CHANNELS - 1) begin mLCh = 0; mLRow++; end
          else mLCh++;
        end
        if (fire) begin
          fired++;
          if (mCc < mK - 1) mCc++;
          else begin
            mCc = 0;
            if (mRr < mK - 1) mRr++;
            else begin
              mRr = 0;
              if (mCh < CHANNELS - 1) mCh++;
              else begin
                mCh = 0;
                mTop += mS;
                if (mTop + mK > mH + mP) mBusy = 0;
              end
            end
          end
        end
      end
    end
  end

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic runCase(int k, int s, int p, int h, int md, bit midStart);
    int expRows, n;
    string tag;
    mode = md;
    fired = 0;
    reqK = k; reqS = s; reqP = p; reqH = h;
    reqStart = 1;
    @(negedge clk);
    @(negedge clk);
    if (midStart) begin
      waitCycles(6);
      reqK = 1; reqS = 1; reqP = 0; reqH = 4;
      reqStart = 1;
    end
    n = 0;
    while ((mBusy || reqStart) && n < 30000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 30000) check(0, "R4 watchdog expired act=busy exp=idle");
    expRows = CHANNELS * k * k * (((h + 2*p - k) / s) + 1);
    tag = midStart ? "R8" : "R4";
    check(fired == expRows, $sformatf("%s row count k=%0d s=%0d p=%0d h=%0d act=%0d exp=%0d",
          tag, k, s, p, h, fired, expRows));
    waitCycles(3);
  endtask

  initial begin
    waitCycles(5);
    rstN = 1'b1;
    waitCycles(1);
    // R1
    check(!busy && !outValid && !inReady,
          $sformatf("R1 reset act=%0d%0d%0d exp=000", busy, outValid, inReady));
    runOn = 1;
    runCase(3, 1, 1, 6, 0, 0);
    runCase(3, 2, 1, 7, 1, 1);
    runCase(1, 1, 0, 4, 0, 0);
    runCase(2, 2, 0, 5, 1, 0);
    runCase(3, 2, 0, 8, 1, 0);
    runCase(2, 1, 1, 3, 1, 0);
    runCase(3, 1, 1, 3, 0, 0);
    // R9
    check(negSeen > 0, $sformatf("R9 negative pixels seen act=%0d exp>0", negSeen));
    runOn = 0;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule